// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector memory command into a stream of byte addresses, one for each element, for a load or store unit to consume. A command gives a base address, an access mode, a signed byte stride, and an element count. The generator can walk memory contiguously, step by a fixed signed distance, or take a per-element offset from an incoming stream of index values. In the last case it performs gather and scatter addressing: each index is scaled to a byte offset and added to the base.

Addresses leave on a valid/ready stream. A held address, with its last flag, stays unchanged until the consumer takes it. In indexed mode the index stream is a second valid/ready stream. An index is consumed in the same cycle as the address built from it, so an address is valid only while an index is valid. An index is taken only while the consumer is ready. With the consumer always ready and indices always present, one address goes out each clock. `start`, `busy` and `done` are plain control pins.

Top module: `vagu_top`

## Requirements
- R1: While reset is asserted, and right after it, `addr_valid`, `idx_ready`, `busy` and `done` are 0.
- R2: Mode 0 (contiguous) gives element k the address base + 8*k.
- R3: Mode 1 (strided) gives element k the address base + k*stride. The stride is a signed 16-bit byte count, and the sum wraps modulo 2^32.
- R4: Mode 2 (indexed) gives element k the address base + 8*idx_k, where idx_k is the k-th accepted index, a signed 16-bit value. `idx_ready` is high only while the command is running in mode 2 and `addr_ready` is high. `addr_valid` follows `idx_valid`.
- R5: In modes 0, 1 and 3, while `addr_valid` is high and `addr_ready` is low, `addr_valid`, `addr_data` and `addr_last` hold for the next cycle.
- R6: In the cycle after `start` is accepted, the first address is valid. With `addr_ready` held high, one address is accepted every cycle with no gaps.
- R7: A command emits exactly its element count of addresses. `addr_last` is high on the final one only.
- R8: `done` is a one-cycle pulse in the cycle after the last address is accepted. `busy` is high from the cycle after acceptance up to and including the `done` cycle.
- R9: An element count of 0 emits no address, and `done` pulses in the cycle after `start`.
- R10: `start` is accepted only when `busy` is low. A `start` that arrives while busy has no effect on the running command.
- R11: An element count above 64 is treated as 64.
- R12: Mode code 3 behaves as mode 0. The base, mode, stride and count are sampled only when `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command request, taken when not busy |
| base_addr | input | 32 | Byte address of element 0 |
| mode | input | 2 | 0 contiguous, 1 strided, 2 indexed, 3 as 0 |
| stride | input | 16 | Signed byte stride for mode 1 |
| vlen | input | 7 | Element count, clamped to 64 |
| idx_valid | input | 1 | Index stream valid |
| idx_data | input | 16 | Signed element index |
| idx_ready | output | 1 | Index accepted when high with idx_valid |
| addr_valid | output | 1 | Address stream valid |
| addr_data | output | 32 | Element byte address |
| addr_last | output | 1 | Marks the final address of a command |
| addr_ready | input | 1 | Consumer ready |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters. These are a 32-bit address, 16-bit stride and index, 8-byte elements and at most 64 elements. With these values the bench can drive a full 64-element command, and a count of 100 shows the clamp. A base near 0xFFFFFFF0 shows address wrap, and negative strides and indices show sign extension. Stalls on the consumer and gaps in the index stream check that the element counter moves only on accepted transfers.

// File: rtl/vagu_pkg.sv
package vagu_pkg;
  typedef enum logic [1:0] {
    AM_CONTIG = 2'd0,
    AM_STRIDE = 2'd1,
    AM_INDEX  = 2'd2,
    AM_ALIAS  = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_FIN  = 2'd2
  } seq_e;
endpackage

// File: rtl/vagu_seq.sv
module vagu_seq
  import vagu_pkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int LW = $clog2(MAX_VL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] vlen,
  input  logic          adv,
  output logic          load,
  output logic          run,
  output logic          fin,
  output logic          last
);
  seq_e          st_q;
  logic [LW-1:0] cnt_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] len_eff;

  assign len_eff = (vlen > LW'(MAX_VL)) ? LW'(MAX_VL) : vlen;
  assign load    = start && (st_q == SQ_IDLE);
  assign run     = (st_q == SQ_RUN);
  assign fin     = (st_q == SQ_FIN);
  assign last    = run && (cnt_q == len_q - LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
      len_q <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: if (load) begin
          cnt_q <= '0;
          len_q <= len_eff;
          st_q  <= (len_eff == '0) ? SQ_FIN : SQ_RUN;
        end
        SQ_RUN: if (adv) begin
          if (last) st_q <= SQ_FIN;
          else      cnt_q <= cnt_q + LW'(1);
        end
        SQ_FIN:  st_q <= SQ_IDLE;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vagu_walk.sv
module vagu_walk #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] step,
  input  logic          adv,
  output logic [AW-1:0] cur
);
  logic [AW-1:0] step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur    <= '0;
      step_q <= '0;
    end else if (load) begin
      cur    <= base;
      step_q <= step;
    end else if (adv) begin
      cur    <= cur + step_q;
    end
  end
endmodule

// File: rtl/vagu_gather.sv
module vagu_gather #(
  parameter int AW = 32,
  parameter int IW = 16,
  parameter int SHIFT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [IW-1:0] idx,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] base_q;
  logic [AW-1:0] off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    base_q <= '0;
    else if (load) base_q <= base;
  end

  always_comb begin
    off  = AW'($signed(idx)) << SHIFT;
    addr = base_q + off;
  end
endmodule

// File: rtl/vagu_top.sv
module vagu_top
  import vagu_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int IW = 16,
  parameter int MAX_VL = 64,
  parameter int ELEM_BYTES = 8,
  localparam int LW = $clog2(MAX_VL + 1),
  localparam int SHIFT = $clog2(ELEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [1:0]    mode,
  input  logic [SW-1:0] stride,
  input  logic [LW-1:0] vlen,
  input  logic          idx_valid,
  input  logic [IW-1:0] idx_data,
  output logic          idx_ready,
  output logic          addr_valid,
  output logic [AW-1:0] addr_data,
  output logic          addr_last,
  input  logic          addr_ready,
  output logic          busy,
  output logic          done
);
  logic          load, run, fin, last, adv;
  logic          is_idx_q;
  amode_e        mode_q;
  logic [AW-1:0] step, walk_addr, gath_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= AM_CONTIG;
      is_idx_q <= 1'b0;
    end else if (load) begin
      mode_q   <= amode_e'(mode);
      is_idx_q <= (amode_e'(mode) == AM_INDEX);
    end
  end

  always_comb begin
    if (amode_e'(mode) == AM_STRIDE) step = AW'($signed(stride));
    else                             step = AW'(ELEM_BYTES);
  end

  vagu_seq #(.MAX_VL(MAX_VL)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen), .adv(adv),
    .load(load), .run(run), .fin(fin), .last(last)
  );

  vagu_walk #(.AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(load), .base(base_addr), .step(step),
    .adv(adv), .cur(walk_addr)
  );

  vagu_gather #(.AW(AW), .IW(IW), .SHIFT(SHIFT)) u_gath (
    .clk(clk), .rst_n(rst_n), .load(load), .base(base_addr), .idx(idx_data),
    .addr(gath_addr)
  );

  assign addr_valid = run && (!is_idx_q || idx_valid);
  assign idx_ready  = run && is_idx_q && addr_ready;
  assign adv        = addr_valid && addr_ready;
  assign addr_data  = is_idx_q ? gath_addr : walk_addr;
  assign addr_last  = last;
  assign busy       = run || fin;
  assign done       = fin;
endmodule

// File: rtl/vagu_checks.sv
module vagu_checks #(
  parameter int AW = 32,
  parameter int ELEM_BYTES = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_valid,
  input logic          addr_ready,
  input logic          addr_last,
  input logic [AW-1:0] addr_data,
  input logic          idx_ready,
  input logic          busy,
  input logic          done,
  input logic [1:0]    mode_q
);
  always_comb begin
    if (rst_n === 1'b0)
      p_reset_quiet_r1: assert (!addr_valid && !idx_ready && !busy && !done);
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready && mode_q != 2'd2)
      |=> (addr_valid && $stable(addr_data) && $stable(addr_last)));

  p_contig_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_ready && !addr_last && mode_q == 2'd0)
      |=> (addr_data == $past(addr_data) + AW'(ELEM_BYTES)));

  p_idx_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ready |-> (addr_ready && busy && !done));

  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_ready && addr_last) |=> done);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_valid_in_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (busy && !done));
endmodule

bind vagu_top vagu_checks #(.AW(AW), .ELEM_BYTES(ELEM_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_ready(addr_ready),
  .addr_last(addr_last), .addr_data(addr_data), .idx_ready(idx_ready),
  .busy(busy), .done(done), .mode_q(mode_q)
);

// File: tb/vagu_top_tb.sv
`timescale 1ns/1ps
module vagu_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [1:0]  mode = '0;
  logic [15:0] stride = '0;
  logic [6:0]  vlen = '0;
  logic        idx_valid = 1'b0;
  logic [15:0] idx_data = '0;
  logic        idx_ready;
  logic        addr_valid;
  logic [31:0] addr_data;
  logic        addr_last;
  logic        addr_ready = 1'b0;
  logic        busy, done;

  int errors = 0;
  int checks = 0;
  logic [15:0] idxv [0:63];

  always #10 clk = ~clk;

  vagu_top u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .mode(mode),
    .stride(stride), .vlen(vlen), .idx_valid(idx_valid), .idx_data(idx_data),
    .idx_ready(idx_ready), .addr_valid(addr_valid), .addr_data(addr_data),
    .addr_last(addr_last), .addr_ready(addr_ready), .busy(busy), .done(done)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Issue one command and collect its addresses against computed values.
  task automatic run_cmd(string tag, logic [31:0] b, logic [1:0] m, logic [15:0] s,
                         int n_req, int n_exp, bit stall, bit gap, bit poke);
    int k = 0;
    int cyc = 0;
    logic [31:0] ex;
    @(negedge clk);
    base_addr = b; mode = m; stride = s; vlen = 7'(n_req); start = 1'b1;
    @(negedge clk);
    start = 1'b0; base_addr = 32'h5A5A_0000; mode = 2'd1; stride = 16'h0100; vlen = 7'd3;
    while (k < n_exp && cyc < 2000) begin
      addr_ready = stall ? (cyc % 3 != 1) : 1'b1;
      idx_valid  = gap ? (cyc % 2 == 0) : 1'b1;
      idx_data   = idxv[k];
      start      = poke && (cyc == 1 || cyc == 2);
      #1;
      if (m == 2'd2) chk(idx_ready == (addr_ready && 1'b1), {tag, " R4 idx_ready"},
                         32'(idx_ready), 32'(addr_ready));
      if (addr_valid && addr_ready) begin
        if (m == 2'd2)      ex = b + (32'($signed(idxv[k])) << 3);
        else if (m == 2'd1) ex = b + 32'(k * $signed(s));
        else                ex = b + 32'(8 * k);
        chk(addr_data == ex, {tag, " addr"}, addr_data, ex);
        chk(addr_last == (k == n_exp - 1), {tag, " R7 last"}, 32'(addr_last),
            32'(k == n_exp - 1));
        k++;
      end else if (!stall && !gap) begin
        chk(1'b0, {tag, " R6 gap in stream"}, 32'(addr_valid), 32'd1);
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0; addr_ready = 1'b0; idx_valid = 1'b0;
    chk(k == n_exp, {tag, " R7 count"}, 32'(k), 32'(n_exp));
    #1;
    chk(done && busy && !addr_valid, {tag, " R8 done"}, {29'd0, done, busy, addr_valid}, 32'd6);
    @(negedge clk); #1;
    chk(!done && !busy, {tag, " R8 idle after done"}, {30'd0, done, busy}, 32'd0);
  endtask

  task automatic t_reset();
    #1;
    chk(!addr_valid && !idx_ready && !busy && !done, "R1 in reset",
        {28'd0, addr_valid, idx_ready, busy, done}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!addr_valid && !busy && !done, "R1 after reset",
        {29'd0, addr_valid, busy, done}, 32'd0);
  endtask

  task automatic t_zero_len();
    @(negedge clk);
    base_addr = 32'h100; mode = 2'd0; vlen = 7'd0; start = 1'b1;
    @(negedge clk); start = 1'b0; #1;
    chk(done && !addr_valid, "R9 zero length done", {30'd0, done, addr_valid}, 32'd2);
    @(negedge clk); #1;
    chk(!busy && !done && !addr_valid, "R9 zero length idle",
        {29'd0, busy, done, addr_valid}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) idxv[i] = 16'(i * 3 - 20);
    t_reset();
    run_cmd("R2 contig",        32'h0000_1000, 2'd0, 16'd0,      5,   5,  0, 0, 0);
    run_cmd("R3 stride pos",    32'h0000_2000, 2'd1, 16'd24,     4,   4,  0, 0, 0);
    run_cmd("R3 stride neg",    32'h0000_3000, 2'd1, 16'hFFF0,   6,   6,  1, 0, 0);
    run_cmd("R3 wrap",          32'hFFFF_FFF0, 2'd0, 16'd0,      4,   4,  0, 0, 0);
    run_cmd("R4 indexed",       32'h0001_0000, 2'd2, 16'd0,      8,   8,  0, 0, 0);
    run_cmd("R4 indexed gaps",  32'h0001_0000, 2'd2, 16'd0,      9,   9,  1, 1, 0);
    run_cmd("R5 stall contig",  32'h0000_4000, 2'd0, 16'd0,      7,   7,  1, 0, 0);
    run_cmd("R10 start busy",   32'h0000_5000, 2'd1, 16'd40,     5,   5,  0, 0, 1);
    run_cmd("R11 clamp",        32'h0000_6000, 2'd0, 16'd0,    100,  64,  0, 0, 0);
    run_cmd("R12 mode3",        32'h0000_7000, 2'd3, 16'd100,    3,   3,  0, 0, 0);
    run_cmd("R6 single",        32'h0000_8000, 2'd1, 16'd8,      1,   1,  0, 0, 0);
    t_zero_len();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule